// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

The block connects two 8-bit buses, A and B, and passes data between them in either direction. Each direction has its own storage register, loaded from its source bus on the rising edge of its own capture clock. A per-direction select chooses what the driven bus sees: the live value from the opposite bus, or the word held in that direction's register. An active-low output enable and a direction input choose which bus is driven, if either.

Each bus is presented as split input, output and output-enable signals, so a tri-state pad wrapper at a higher level can merge them onto a shared wire. The output path is combinational. Only the two registers are clocked, and they load on every rising edge of their clock whatever the drive state is. This lets a bus be sampled while both sides are released.

Top module: `xcvr_regbus`

## Requirements
- R1: The data paths are `DATA_W` bits wide (8 by default) and non-inverting: a value routed from one side appears unchanged, bit for bit, on the other side's output.
- R2: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R3: While `oe_n` is 0, `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0, and `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0. The two enables are never 1 together.
- R4: On every rising edge of `clk_ab`, the A-to-B register loads `a_in`, whatever the values of `oe_n` and `dir`.
- R5: On every rising edge of `clk_ba`, the B-to-A register loads `b_in`, whatever the values of `oe_n` and `dir`.
- R6: `b_out` equals `a_in` when `sel_ab` = 0, and equals the A-to-B register when `sel_ab` = 1.
- R7: `a_out` equals `b_in` when `sel_ba` = 0, and equals the B-to-A register when `sel_ba` = 1.
- R8: Both registers load while `oe_n` = 1. When both clocks rise in the same instant, both registers update.
- R9: While `rst_n` is 0, both registers are zero. After `rst_n` rises, the first two rising edges of a register's own clock leave it at zero, and the third edge loads it.
- R10: A rising edge of one capture clock leaves the other direction's register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_ba | input | 1 | Capture clock of the B-to-A register (rising edge) |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised to each capture clock |
| oe_n | input | 1 | Active-low output enable; 1 releases both buses |
| dir | input | 1 | Driven side while enabled: 0 drives A, 1 drives B |
| sel_ab | input | 1 | Source for B side: 0 live A, 1 stored A-to-B word |
| sel_ba | input | 1 | Source for A side: 0 live B, 1 stored B-to-A word |
| a_in | input | DATA_W | Value sensed on bus A |
| a_out | output | DATA_W | Value offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | DATA_W | Value sensed on bus B |
| b_out | output | DATA_W | Value offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
A register loaded while both buses are released cannot be observed at that moment. Its contents are hidden until the enable, direction and select inputs are later set to stored mode toward the matching side. The bench loads words with `oe_n` high, sometimes with both clocks pulsed in the same instant. It then changes the live bus inputs to unrelated values before it opens each direction in stored mode, so a live path or a missed load reads back as a mismatch. The synchronised reset release is shown by counting the capture edges at which a non-zero bus word first becomes visible.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_side_e;

  function automatic drive_side_e decode_side(input logic oe_n, input logic dir);
    if (oe_n)     return DRV_NONE;
    else if (dir) return DRV_B;
    else          return DRV_A;
  endfunction

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] ab_q,
  input  logic [W-1:0] ba_q,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  drive_side_e side;

  always_comb begin
    side  = decode_side(oe_n, dir);
    a_oe  = (side == DRV_A);
    b_oe  = (side == DRV_B);
    b_out = sel_ab ? ab_q : a_in;
    a_out = sel_ba ? ba_q : b_in;
  end

endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus #(
  parameter int DATA_W    = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk_ab,
  input  logic              clk_ba,
  input  logic              rst_n,
  input  logic              oe_n,
  input  logic              dir,
  input  logic              sel_ab,
  input  logic              sel_ba,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe
);

  logic              ab_rst_n;
  logic              ba_rst_n;
  logic [DATA_W-1:0] ab_q;
  logic [DATA_W-1:0] ba_q;

  xcvr_rst_sync #(.STAGES(SYNC_STG)) u_rs_ab (
    .clk(clk_ab), .rst_n(rst_n), .rst_sync_n(ab_rst_n)
  );

  xcvr_rst_sync #(.STAGES(SYNC_STG)) u_rs_ba (
    .clk(clk_ba), .rst_n(rst_n), .rst_sync_n(ba_rst_n)
  );

  xcvr_cap_reg #(.W(DATA_W)) u_reg_ab (
    .clk(clk_ab), .rst_n(ab_rst_n), .d(a_in), .q(ab_q)
  );

  xcvr_cap_reg #(.W(DATA_W)) u_reg_ba (
    .clk(clk_ba), .rst_n(ba_rst_n), .d(b_in), .q(ba_q)
  );

  xcvr_drive_ctl #(.W(DATA_W)) u_drv (
    .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .b_in(b_in), .ab_q(ab_q), .ba_q(ba_q),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

endmodule

// File: rtl/xcvr_regbus_chk.sv
module xcvr_regbus_chk #(
  parameter int W = 8
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst_n,
  input logic         ab_rst_n,
  input logic         ba_rst_n,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q
);

  a_r3_single_side: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !(a_oe && b_oe));

  a_r2_isolated: assert property (@(posedge clk_ba) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe));

  a_r4_ab_load: assert property (@(posedge clk_ab) disable iff (!rst_n)
    ab_rst_n |=> (ab_q == $past(a_in)));

  a_r5_ba_load: assert property (@(posedge clk_ba) disable iff (!rst_n)
    ba_rst_n |=> (ba_q == $past(b_in)));

  a_r6_b_stored: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir && sel_ab) |-> (b_oe && b_out == ab_q));

  a_r7_a_live: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && !dir && !sel_ba) |-> (a_oe && a_out == b_in));

endmodule

bind xcvr_regbus xcvr_regbus_chk #(.W(DATA_W)) chk_i (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
  .ab_rst_n(ab_rst_n), .ba_rst_n(ba_rst_n),
  .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
  .a_oe(a_oe), .b_oe(b_oe), .ab_q(ab_q), .ba_q(ba_q)
);

// File: tb/xcvr_regbus_tb_top.sv
`timescale 1ns/1ps
module xcvr_regbus_tb_top;

  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic         oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  xcvr_regbus #(.DATA_W(W)) dut_i (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit ab, input bit ba);
    @(negedge clk);
    clk_ab = ab; clk_ba = ba;
    #2.5;
    clk_ab = 1'b0; clk_ba = 1'b0;
    #1;
  endtask

  task automatic set_ctl(input logic oe, input logic d, input logic sab, input logic sba);
    oe_n = oe; dir = d; sel_ab = sab; sel_ba = sba;
    #1;
  endtask

  task automatic t_reset;
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    a_in = 8'h5A; b_in = 8'hC3; #1;
    chk("R9 reset AB reg", b_out, 8'h00);
    chk("R9 reset BA reg", a_out, 8'h00);
    rst_n = 1'b1; #1;
    pulse(1, 1);
    chk("R9 edge1 AB held", b_out, 8'h00);
    pulse(1, 1);
    chk("R9 edge2 AB held", b_out, 8'h00);
    chk("R9 edge2 BA held", a_out, 8'h00);
    pulse(1, 1);
    chk("R9 edge3 AB loads", b_out, 8'h5A);
    chk("R9 edge3 BA loads", a_out, 8'hC3);
  endtask

  task automatic t_enables;
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 iso dir0", {6'd0, a_oe, b_oe}, 8'd0);
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 iso dir1", {6'd0, a_oe, b_oe}, 8'd0);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 drive A", {6'd0, a_oe, b_oe}, 8'd2);
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 drive B", {6'd0, a_oe, b_oe}, 8'd1);
  endtask

  task automatic t_live;
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    a_in = 8'hA5; #1;
    chk("R6 R1 live A to B", b_out, 8'hA5);
    a_in = 8'h01; #1;
    chk("R1 live bit0", b_out, 8'h01);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    b_in = 8'h80; #1;
    chk("R7 R1 live B to A", a_out, 8'h80);
  endtask

  task automatic t_stored_driving;
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    a_in = 8'h3C; b_in = 8'h96;
    pulse(1, 0);
    a_in = 8'hFF; #1;
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R4 R6 AB load while A driven", b_out, 8'h3C);
    chk("R10 BA unchanged by clk_ab", a_out, 8'hC3);
    b_in = 8'h69;
    pulse(0, 1);
    b_in = 8'h00; a_in = 8'h11; #1;
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5 R7 BA load", a_out, 8'h69);
    chk("R10 AB unchanged by clk_ba", b_out, 8'h3C);
  endtask

  task automatic t_isolation;
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    a_in = 8'hE7; b_in = 8'h18;
    pulse(1, 1);
    a_in = 8'h00; b_in = 8'hFF; #1;
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8 simultaneous AB", b_out, 8'hE7);
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 simultaneous BA", a_out, 8'h18);
    set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
    a_in = 8'h42;
    pulse(1, 0);
    a_in = 8'h00; #1;
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8 isolated AB alone", b_out, 8'h42);
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 R10 BA kept", a_out, 8'h18);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #7;
    t_reset();
    t_enables();
    t_live();
    t_stored_driving();
    t_isolation();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule